// File: doc/BRIEF.md
# Framed Serial I/Q Output Port

This block takes decimated I/Q sample pairs from a filter chain and sends each pair to a downstream signal processor over a shared serial line. It makes its own serial clock by dividing the system clock by a run-time integer, which may be even or odd. A sample pair written in is held in a one-deep buffer, and a data-ready flag is raised. At the next rising serial-clock edge a frame begins. The frame carries the I word and then the Q word, each most significant bit first, one bit per serial-clock period.

A frame-sync output marks each frame. Software picks one of three shapes for it: a one-period pulse ahead of the first bit, a pulse over the first bit only, or a level held for the whole frame. The data line drives only during the frame's bit periods and is high-impedance at all other times. This lets several ports share one processor input. A pair that arrives while a frame is still shifting waits in the buffer and goes out in the frame that follows directly. If more pairs arrive before that frame starts, the newest one replaces the waiting one.

Top module: `sio_frame_port`

## Requirements
- R1: With `div_ratio` = N (values below 2 act as 2), `sclk` has a period of N clock cycles. It is high for ceil(N/2) cycles and low for floor(N/2) cycles. A new ratio takes effect at the next serial-clock period boundary.
- R2: A frame for a buffered pair begins at the first `sclk` rising edge after the pair is loaded. The first frame-sync period of that frame is that serial-clock period.
- R3: With `fs_mode` 0 (and 3, which behaves the same), `fsync` is high for exactly one serial-clock period directly before the first data bit, and `sdo_oe` is low during that period.
- R4: With `fs_mode` 1, `fsync` is high during the period of the first data bit (I MSB) only.
- R5: With `fs_mode` 2, `fsync` is high during all 2*WORD_W data-bit periods of the frame.
- R6: Each frame sends `in_i` MSB first and then `in_q` MSB first, so the last bit is the LSB of Q. Exactly one bit goes out per serial-clock period, and `sdo` changes only together with an `sclk` rising edge.
- R7: `sdo_oe` is high exactly during the frame's 2*WORD_W data-bit periods. At all other times `sdo` is high-impedance and `fsync` is low (except in the mode-0 sync period).
- R8: `drdy` goes high on the clock after `in_valid` is sampled. It stays high until the frame that carries that pair starts, and it falls together with that frame's first `sclk` rising edge.
- R9: A pair that arrives while a frame is in progress is sent in the next frame. That frame starts in the serial-clock period directly after the last bit of the current frame.
- R10: When several pairs arrive during one frame, only the most recent one is sent afterwards. The earlier ones are dropped and produce no frame.
- R11: While `rst_n` is low, `sclk`, `fsync`, `sdo_oe` and `drdy` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ratio | input | DIV_W | Serial clock divide ratio N (minimum 2) |
| fs_mode | input | 2 | Frame-sync shape: 0/3 lead pulse, 1 first-bit pulse, 2 whole-frame level |
| in_valid | input | 1 | New sample pair present this cycle |
| in_i | input | WORD_W | I sample |
| in_q | input | WORD_W | Q sample |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync |
| sdo | output | 1 | Serial data, high-impedance outside the time slot |
| sdo_oe | output | 1 | High while `sdo` is driven |
| drdy | output | 1 | A sample pair is buffered and waiting for its frame |

## Verification
Every output is registered. `drdy` is due one clock after `in_valid`. The frame's first sync or data period is due at the first `sclk` rise after that. Each later bit is due exactly one `sclk` rise after the previous one. The bench never counts raw clocks to find bits. It waits for each observed rising edge of `sclk`, sampling on the falling system-clock edge, and then checks `fsync`, `sdo_oe`, `sdo` and `drdy` for that serial period. This keeps the expected slot for every bit correct for any divide ratio. Divider duty is measured as runs of high and low samples between consecutive observed edges.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2
    } frm_state_e;

    typedef enum logic [1:0] {
        FS_LEAD     = 2'd0,
        FS_FIRST    = 2'd1,
        FS_SPAN     = 2'd2,
        FS_LEAD_ALT = 2'd3
    } fs_mode_e;

endpackage

// File: rtl/sio_clkdiv.sv
module sio_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             sclk_o,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] MIN_RATIO = DIV_W'(2);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] ratio;
        logic             sclk;
    } div_reg_t;

    div_reg_t r_d, r_q;

    logic [DIV_W-1:0] ratio_in;
    logic [DIV_W:0]   hi_sum;
    logic [DIV_W-1:0] hi_len;
    logic             tick;

    always_comb begin
        ratio_in = (div_ratio < MIN_RATIO) ? MIN_RATIO : div_ratio;
        hi_sum   = {1'b0, r_q.ratio} + 1'b1;
        hi_len   = hi_sum[DIV_W:1];
        tick     = (r_q.cnt >= (r_q.ratio - 1'b1));

        r_d = r_q;
        if (tick) begin
            r_d.cnt   = '0;
            r_d.ratio = ratio_in;
            r_d.sclk  = 1'b1;
        end else begin
            r_d.cnt  = r_q.cnt + 1'b1;
            r_d.sclk = (r_d.cnt < hi_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt   <= DIV_W'(1);
            r_q.ratio <= MIN_RATIO;
            r_q.sclk  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk_o = r_q.sclk;
    assign tick_o = tick;

    // R1: serial clock rises only at the start of a divider period
    assert_rise_at_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sclk) |-> (r_q.cnt == '0));

    // R1: the counter never passes the ratio it is running with
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cnt != '0) |-> (r_q.cnt < r_q.ratio));

endmodule

// File: rtl/sio_hold.sv
module sio_hold #(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_i,
    input  logic [WORD_W-1:0]   in_q,
    input  logic                take,
    output logic                full_o,
    output logic [2*WORD_W-1:0] pair_o
);

    localparam int PAIR_W = 2 * WORD_W;

    typedef struct packed {
        logic              full;
        logic [PAIR_W-1:0] pair;
    } hold_reg_t;

    hold_reg_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (in_valid) begin
            h_d.full = 1'b1;
            h_d.pair = {in_i, in_q};
        end else if (take) begin
            h_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign full_o = h_q.full;
    assign pair_o = h_q.pair;

    // R8: the framer only takes a pair that is present
    assert_take_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> h_q.full);

    // R8: the buffer empties only by being taken
    assert_empty_by_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h_q.full) |-> $past(take));

endmodule

// File: rtl/sio_framer.sv
module sio_framer
    import sio_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [1:0]          fs_mode,
    input  logic                full,
    input  logic [2*WORD_W-1:0] pair,
    output logic                take,
    output logic                sdo_o,
    output logic                oe_o,
    output logic                fs_o
);

    localparam int FRAME_BITS = 2 * WORD_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        frm_state_e            state;
        logic [FRAME_BITS-1:0] shreg;
        logic [CNT_W-1:0]      bitcnt;
        logic                  sdo;
        logic                  oe;
        logic                  fs;
    } frm_reg_t;

    frm_reg_t f_d, f_q;
    fs_mode_e mode;
    logic     lead;

    always_comb begin
        mode = fs_mode_e'(fs_mode);
        lead = (mode == FS_LEAD) || (mode == FS_LEAD_ALT);
        take = 1'b0;
        f_d  = f_q;

        if (tick) begin
            case (f_q.state)
                ST_IDLE: begin
                    if (full) begin
                        take       = 1'b1;
                        f_d.shreg  = pair;
                        f_d.bitcnt = '0;
                        f_d.state  = lead ? ST_SYNC : ST_SHIFT;
                    end
                end
                ST_SYNC: begin
                    f_d.bitcnt = '0;
                    f_d.state  = ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (f_q.bitcnt == LAST_BIT) begin
                        if (full) begin
                            take       = 1'b1;
                            f_d.shreg  = pair;
                            f_d.bitcnt = '0;
                            f_d.state  = lead ? ST_SYNC : ST_SHIFT;
                        end else begin
                            f_d.state = ST_IDLE;
                        end
                    end else begin
                        f_d.bitcnt = f_q.bitcnt + 1'b1;
                        f_d.shreg  = {f_q.shreg[FRAME_BITS-2:0], 1'b0};
                    end
                end
                default: f_d.state = ST_IDLE;
            endcase
        end

        f_d.oe  = (f_d.state == ST_SHIFT);
        f_d.sdo = f_d.oe & f_d.shreg[FRAME_BITS-1];
        case (mode)
            FS_FIRST: f_d.fs = f_d.oe && (f_d.bitcnt == '0);
            FS_SPAN:  f_d.fs = f_d.oe;
            default:  f_d.fs = (f_d.state == ST_SYNC);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.state  <= ST_IDLE;
            f_q.shreg  <= '0;
            f_q.bitcnt <= '0;
            f_q.sdo    <= 1'b0;
            f_q.oe     <= 1'b0;
            f_q.fs     <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign sdo_o = f_q.sdo;
    assign oe_o  = f_q.oe;
    assign fs_o  = f_q.fs;

    // R2: frame state moves only on a serial period boundary from the divider
    assert_state_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state != $past(f_q.state)) |-> $past(tick));

    // R3: in lead mode the sync period never drives data
    assert_lead_sync_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.fs && lead) |-> !f_q.oe);

    // R6: a time slot always opens on the first bit of the frame
    assert_slot_opens_at_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.oe) |-> (f_q.bitcnt == '0));

endmodule

// File: rtl/sio_frame_port.sv
module sio_frame_port #(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic [1:0]        fs_mode,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_i,
    input  logic [WORD_W-1:0] in_q,
    output logic              sclk,
    output logic              fsync,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              drdy
);

    localparam int PAIR_W = 2 * WORD_W;

    logic              tick;
    logic              take;
    logic              full;
    logic [PAIR_W-1:0] pair;
    logic              bit_out;
    logic              oe;

    sio_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_ratio (div_ratio),
        .sclk_o    (sclk),
        .tick_o    (tick)
    );

    sio_hold #(.WORD_W(WORD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .take     (take),
        .full_o   (full),
        .pair_o   (pair)
    );

    sio_framer #(.WORD_W(WORD_W)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .fs_mode (fs_mode),
        .full    (full),
        .pair    (pair),
        .take    (take),
        .sdo_o   (bit_out),
        .oe_o    (oe),
        .fs_o    (fsync)
    );

    assign sdo    = oe ? bit_out : 1'bz;
    assign sdo_oe = oe;
    assign drdy   = full;

    // R8: data-ready clears only at a serial period boundary
    assert_drdy_clears_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy) |-> $past(tick));

    // R6: the data line changes only with a rising serial clock
    assert_sdo_with_sclk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && (bit_out != $past(bit_out))) |-> $rose(sclk));

endmodule

// File: tb/test_sio_frame_port.sv
`timescale 1ns/1ps
module test_sio_frame_port;

    localparam int W     = 16;
    localparam int DW    = 8;
    localparam int WD_NS = 100000 * 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] div_ratio = DW'(4);
    logic [1:0]    fs_mode = 2'd0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_i = '0;
    logic [W-1:0]  in_q = '0;
    logic          sclk, fsync, sdo, sdo_oe, drdy;

    int n_run  = 0;
    int n_fail = 0;
    bit timeout = 0;

    always #2.5 clk = ~clk;

    sio_frame_port #(.WORD_W(W), .DIV_W(DW)) i_sio_frame_port (
        .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .fs_mode(fs_mode),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .sclk(sclk), .fsync(fsync), .sdo(sdo), .sdo_oe(sdo_oe), .drdy(drdy)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // wait for the next observed rising edge of sclk, sampled on falling clk
    task automatic next_period();
        logic p;
        p = sclk;
        for (int g = 0; g < 2000; g++) begin
            @(negedge clk);
            if (sclk && !p) return;
            p = sclk;
        end
    endtask

    task automatic send(input logic [W-1:0] vi, input logic [W-1:0] vq);
        @(negedge clk);
        in_valid = 1'b1;
        in_i = vi;
        in_q = vq;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic recv_frame(input logic [1:0] mode, input logic [W-1:0] ei,
                              input logic [W-1:0] eq, input bit first);
        logic [2*W-1:0] fr;
        bit lead;
        bit found;
        int k;
        logic exp_fs;
        fr = {ei, eq};
        lead = (mode == 2'd0) || (mode == 2'd3);
        found = 0;
        k = 0;
        for (int t = 0; t < 6; t++) begin
            next_period();
            if (fsync) begin found = 1; k = t; break; end
        end
        chk("R2", "frame sync seen", found, 1);
        if (first) chk("R2", "frame starts at first sclk rise", k, 0);
        chk("R8", "drdy cleared at frame start", drdy, 0);
        if (lead) chk("R3", "no drive in sync period", sdo_oe, 0);
        for (int b = 0; b < 2*W; b++) begin
            if (lead || b != 0) next_period();
            chk("R7", "oe during bit", sdo_oe, 1);
            chk("R6", $sformatf("bit %0d", b), sdo, fr[2*W-1-b]);
            if (lead) exp_fs = 1'b0;
            else if (mode == 2'd1) exp_fs = (b == 0);
            else exp_fs = 1'b1;
            chk(lead ? "R3" : (mode == 2'd1 ? "R4" : "R5"),
                $sformatf("fsync at bit %0d", b), fsync, exp_fs);
        end
    endtask

    task automatic expect_idle(input int n, input string req);
        for (int t = 0; t < n; t++) begin
            next_period();
            chk(req, "slot closed when idle", sdo_oe, 0);
            chk(req, "no sync when idle", fsync, 0);
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R11", "sclk in reset", sclk, 0);
        chk("R11", "fsync in reset", fsync, 0);
        chk("R11", "oe in reset", sdo_oe, 0);
        chk("R11", "drdy in reset", drdy, 0);
        rst_n = 1'b1;
        expect_idle(3, "R7");
    endtask

    task automatic t_divider(input int n, input int hi, input int lo);
        int hc;
        int lc;
        div_ratio = DW'(n);
        next_period();
        next_period();
        next_period();
        hc = 1;
        for (int g = 0; g < 600; g++) begin
            @(negedge clk);
            if (sclk) hc++; else break;
        end
        lc = 1;
        for (int g = 0; g < 600; g++) begin
            @(negedge clk);
            if (!sclk) lc++; else break;
        end
        chk("R1", $sformatf("high cycles N=%0d", n), hc, hi);
        chk("R1", $sformatf("low cycles N=%0d", n), lc, lo);
    endtask

    task automatic t_single(input logic [1:0] mode, input int n,
                            input logic [W-1:0] vi, input logic [W-1:0] vq);
        fs_mode = mode;
        div_ratio = DW'(n);
        next_period();
        next_period();
        send(vi, vq);
        chk("R8", "drdy one clock after load", drdy, 1);
        recv_frame(mode, vi, vq, 1);
        expect_idle(2, "R7");
    endtask

    task automatic t_back_to_back(input logic [1:0] mode);
        fs_mode = mode;
        div_ratio = DW'(4);
        next_period();
        send(16'h1234, 16'h8001);
        fork
            recv_frame(mode, 16'h1234, 16'h8001, 1);
            begin
                repeat (20) @(negedge clk);
                send(16'hF00D, 16'h0FF1);
            end
        join
        recv_frame(mode, 16'hF00D, 16'h0FF1, 1);   // R9: follows directly
        expect_idle(2, "R9");
    endtask

    task automatic t_overwrite();
        fs_mode = 2'd0;
        div_ratio = DW'(3);
        next_period();
        send(16'h00FF, 16'hFF00);
        fork
            recv_frame(2'd0, 16'h00FF, 16'hFF00, 1);
            begin
                repeat (15) @(negedge clk);
                send(16'hDEAD, 16'hBEEF);
                repeat (15) @(negedge clk);
                send(16'h5A5A, 16'hA5A5);
            end
        join
        recv_frame(2'd0, 16'h5A5A, 16'hA5A5, 1);   // R10: newest pair only
        expect_idle(4, "R10");
    endtask

    task automatic run_all();
        t_reset();
        t_divider(4, 2, 2);
        t_divider(5, 3, 2);
        t_divider(2, 1, 1);
        t_divider(1, 1, 1);
        t_divider(7, 4, 3);
        t_single(2'd0, 4, 16'hA55A, 16'h0001);
        t_single(2'd1, 5, 16'h8000, 16'h7FFF);
        t_single(2'd2, 3, 16'hC3C3, 16'h1E1E);
        t_single(2'd3, 2, 16'h0F0F, 16'hF0F1);
        t_back_to_back(2'd0);
        t_back_to_back(2'd1);
        t_overwrite();
    endtask

    initial begin
        fork
            run_all();
            begin
                #(WD_NS);
                timeout = 1;
            end
        join_any
        if (timeout) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule